// File: doc/BRIEF.md
# Two-Lane Receive Symbol Order Restorer

This block sits behind a deserializer in a receive path that carries two symbols per word. Each symbol is a data field of `SYM_W` bits plus a control indicator. The block looks for a programmed ordering pattern in the stream. That pattern is either one symbol or a sequence of two symbols. Correct order means the pattern starts in lane 0, the least significant lane. When the pattern starts in lane 1, the block inserts one pad symbol into lane 0. It then runs every later symbol one lane late through a one-symbol holding register, so the pattern and everything after it move to the right lanes. No symbol is dropped.

An operation is armed in one of two ways. In automatic mode, reset or a pulse on `resync_i` arms it. In manual mode, each rising edge of `ord_en_i` arms it. An armed operation completes at the first match it sees. Matches after that are ignored until the block is armed again. The block pulses `ord_flag_o` together with the output word in which the reorder takes effect. Words pass from input to output with a fixed latency of two clock cycles. The extra cycle lets the detector see whether a two-symbol pattern that starts in lane 1 is completed by the next word.

Top module: `rx_symbol_orderer`

## Requirements
- R1: While reset is asserted, `rxd_o`, `rxk_o` and `ord_flag_o` are all zero.
- R2: When no reorder is active, each input word appears unchanged on `rxd_o`/`rxk_o` two clock cycles after it is sampled.
- R3: Single-symbol mode, armed: a word that holds the pattern in lane 1 (bits `[2*SYM_W-1:SYM_W]`) is output as {lane 1 = its lane 0 symbol, lane 0 = pad}. `ord_flag_o` is high in that same output cycle, and the pattern appears in lane 0 of the next output word.
- R4: After a pad insertion, each output word carries the previous input word's lane 1 symbol in lane 0 and the current word's lane 0 symbol in lane 1. This holds until the block is re-armed.
- R5: When an armed match finds the pattern already in lane 0, no pad is inserted. The word passes unchanged, and `ord_flag_o` is high for exactly that one output word.
- R6: Two-symbol mode (`PAT_LEN`=2): the pattern is ORD_SYM0 followed by ORD_SYM1. ORD_SYM0 in lane 0 with ORD_SYM1 in lane 1 of the same word is aligned. ORD_SYM0 in lane 1 with ORD_SYM1 in lane 0 of the next word triggers a pad. ORD_SYM0 in lane 1 followed by anything else does nothing.
- R7: Bit `SYM_W` of each programmed symbol is its control indicator (`rxk_i[0]`/`rxk_o[0]` belong to lane 0 and `[1]` to lane 1). With `USE_K`=1, a match requires the indicator to be equal. The inserted pad carries `PAD_SYM[SYM_W]` as its indicator, and every other indicator moves with its symbol.
- R8: Automatic mode: only the first match after reset or after a `resync_i` pulse causes an operation. `resync_i` also returns the datapath to pass-through.
- R9: Manual mode: no operation happens until `ord_en_i` rises. Holding it high allows only one operation. A fresh low-to-high edge re-arms the block and returns it to pass-through. `resync_i` has no effect in this mode.
- R10: Single-symbol mode: if both lanes hold the pattern, the word counts as aligned and no pad is inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive word clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rxd_i | input | 2*SYM_W | Received word data, lane 0 in the low bits |
| rxk_i | input | 2 | Control indicator per lane |
| ord_en_i | input | 1 | Manual-mode arming input, acts on its rising edge |
| resync_i | input | 1 | Automatic-mode re-arm and return to pass-through |
| rxd_o | output | 2*SYM_W | Reordered word data |
| rxk_o | output | 2 | Reordered control indicators |
| ord_flag_o | output | 1 | High in the output cycle where a reorder takes effect |

## Verification
The properties assume the inputs are known from the first cycle after reset release. They compare outputs with input values up to three cycles back, so a stream with X or Z values would make those comparisons meaningless. The properties also assume that re-arming never coincides with a pad insertion, and the arming logic guarantees this by suppressing a match on the cycle a re-arm arrives. The stimulus drives every input at the falling clock edge and drives zero between scenarios. Pattern words are placed only where a scenario intends a match, so each expected output word can be worked out by hand from the lane rules.

// File: rtl/rso_pkg.sv
package rso_pkg;
  localparam int LANES = 2;

  typedef enum logic [0:0] {
    ORD_AUTO   = 1'b0,
    ORD_MANUAL = 1'b1
  } ord_mode_e;
endpackage

// File: rtl/rso_rst_sync.sv
module rso_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/rso_match.sv
module rso_match #(
  parameter int             SYM_W    = 8,
  parameter int             USE_K    = 1,
  parameter int             PAT_LEN  = 1,
  parameter logic [SYM_W:0] ORD_SYM0 = 9'h1BC,
  parameter logic [SYM_W:0] ORD_SYM1 = 9'h13C
) (
  input  logic [rso_pkg::LANES*SYM_W-1:0] stg_d,
  input  logic [rso_pkg::LANES-1:0]       stg_k,
  input  logic [SYM_W-1:0]                nxt_d,
  input  logic                            nxt_k,
  output logic                            hit_lo,
  output logic                            hit_hi
);
  localparam int LN = rso_pkg::LANES;

  function automatic logic sym_hit(input logic [SYM_W-1:0] d, input logic k,
                                   input logic [SYM_W:0] pat);
    return (d == pat[SYM_W-1:0]) && ((USE_K == 0) || (k == pat[SYM_W]));
  endfunction

  logic [LN-1:0] p0_at;
  logic          p1_hi;
  logic          p1_nxt;

  for (genvar l = 0; l < LN; l++) begin : g_lane
    assign p0_at[l] = sym_hit(stg_d[l*SYM_W +: SYM_W], stg_k[l], ORD_SYM0);
  end

  assign p1_hi  = sym_hit(stg_d[LN*SYM_W-1 -: SYM_W], stg_k[LN-1], ORD_SYM1);
  assign p1_nxt = sym_hit(nxt_d, nxt_k, ORD_SYM1);

  always_comb begin
    if (PAT_LEN == 1) begin
      hit_lo = p0_at[0];
      hit_hi = p0_at[1];
    end else begin
      hit_lo = p0_at[0] & p1_hi;
      hit_hi = p0_at[1] & p1_nxt;
    end
  end
endmodule

// File: rtl/rso_arm.sv
module rso_arm #(
  parameter rso_pkg::ord_mode_e ORD_MODE = rso_pkg::ORD_AUTO
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic resync_i,
  input  logic hit_lo,
  input  logic hit_hi,
  output logic pad_now,
  output logic clr_shift,
  output logic flag_o
);
  localparam logic ARM_RST = (ORD_MODE == rso_pkg::ORD_AUTO);

  logic en_q, armed_q, flag_q;
  logic en_n, armed_n, flag_n;
  logic rise, rearm, done;

  always_comb begin
    rise = en_i & ~en_q;
    if (ORD_MODE == rso_pkg::ORD_MANUAL) rearm = rise;
    else                                 rearm = resync_i;
    clr_shift = rearm;
    // a re-arm cycle never completes an operation: keeps pad and clear apart
    done    = armed_q & ~rearm & (hit_lo | hit_hi);
    pad_now = done & ~hit_lo;
    armed_n = rearm | (armed_q & ~done);
    flag_n  = done;
    en_n    = en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      armed_q <= ARM_RST;
      flag_q  <= 1'b0;
    end else begin
      en_q    <= en_n;
      armed_q <= armed_n;
      flag_q  <= flag_n;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/rso_lanes.sv
module rso_lanes #(
  parameter int             SYM_W   = 8,
  parameter int             USE_K   = 1,
  parameter logic [SYM_W:0] PAD_SYM = 9'h1F7
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [rso_pkg::LANES*SYM_W-1:0] in_d,
  input  logic [rso_pkg::LANES-1:0]       in_k,
  input  logic                            pad_now,
  input  logic                            clr_shift,
  output logic [rso_pkg::LANES*SYM_W-1:0] stg_d,
  output logic [rso_pkg::LANES-1:0]       stg_k,
  output logic [rso_pkg::LANES*SYM_W-1:0] out_d,
  output logic [rso_pkg::LANES-1:0]       out_k,
  output logic                            shifted
);
  localparam int   DW    = rso_pkg::LANES * SYM_W;
  localparam logic PAD_K = (USE_K != 0) ? PAD_SYM[SYM_W] : 1'b0;

  logic [DW-1:0]    stg_d_q, stg_d_n, out_d_q, out_d_n;
  logic [1:0]       stg_k_q, stg_k_n, out_k_q, out_k_n;
  logic [SYM_W-1:0] hold_d_q, hold_d_n;
  logic             hold_k_q, hold_k_n;
  logic             shift_q, shift_n;

  always_comb begin
    stg_d_n  = in_d;
    stg_k_n  = in_k;
    hold_d_n = stg_d_q[DW-1 -: SYM_W];
    hold_k_n = stg_k_q[1];
    if (pad_now) begin
      out_d_n = {stg_d_q[SYM_W-1:0], PAD_SYM[SYM_W-1:0]};
      out_k_n = {stg_k_q[0], PAD_K};
    end else if (shift_q) begin
      out_d_n = {stg_d_q[SYM_W-1:0], hold_d_q};
      out_k_n = {stg_k_q[0], hold_k_q};
    end else begin
      out_d_n = stg_d_q;
      out_k_n = stg_k_q;
    end
    if (clr_shift)    shift_n = 1'b0;
    else if (pad_now) shift_n = 1'b1;
    else              shift_n = shift_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_d_q  <= '0;
      stg_k_q  <= '0;
      hold_d_q <= '0;
      hold_k_q <= 1'b0;
      shift_q  <= 1'b0;
      out_d_q  <= '0;
      out_k_q  <= '0;
    end else begin
      stg_d_q  <= stg_d_n;
      stg_k_q  <= stg_k_n;
      hold_d_q <= hold_d_n;
      hold_k_q <= hold_k_n;
      shift_q  <= shift_n;
      out_d_q  <= out_d_n;
      out_k_q  <= out_k_n;
    end
  end

  assign stg_d   = stg_d_q;
  assign stg_k   = stg_k_q;
  assign out_d   = out_d_q;
  assign out_k   = out_k_q;
  assign shifted = shift_q;
endmodule

// File: rtl/rx_symbol_orderer.sv
module rx_symbol_orderer #(
  parameter int                 SYM_W    = 8,
  parameter int                 USE_K    = 1,
  parameter int                 PAT_LEN  = 1,
  parameter rso_pkg::ord_mode_e ORD_MODE = rso_pkg::ORD_AUTO,
  parameter logic [SYM_W:0]     ORD_SYM0 = 9'h1BC,
  parameter logic [SYM_W:0]     ORD_SYM1 = 9'h13C,
  parameter logic [SYM_W:0]     PAD_SYM  = 9'h1F7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2*SYM_W-1:0] rxd_i,
  input  logic [1:0]         rxk_i,
  input  logic               ord_en_i,
  input  logic               resync_i,
  output logic [2*SYM_W-1:0] rxd_o,
  output logic [1:0]         rxk_o,
  output logic               ord_flag_o
);
  localparam int DW = rso_pkg::LANES * SYM_W;

  logic          rst_s_n;
  logic [DW-1:0] stg_d;
  logic [1:0]    stg_k;
  logic          hit_lo, hit_hi;
  logic          pad_now, clr_shift, shifted;

  rso_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_s_n)
  );

  rso_lanes #(.SYM_W(SYM_W), .USE_K(USE_K), .PAD_SYM(PAD_SYM)) u_lanes (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .in_d      (rxd_i),
    .in_k      (rxk_i),
    .pad_now   (pad_now),
    .clr_shift (clr_shift),
    .stg_d     (stg_d),
    .stg_k     (stg_k),
    .out_d     (rxd_o),
    .out_k     (rxk_o),
    .shifted   (shifted)
  );

  rso_match #(
    .SYM_W(SYM_W), .USE_K(USE_K), .PAT_LEN(PAT_LEN),
    .ORD_SYM0(ORD_SYM0), .ORD_SYM1(ORD_SYM1)
  ) u_match (
    .stg_d  (stg_d),
    .stg_k  (stg_k),
    .nxt_d  (rxd_i[SYM_W-1:0]),
    .nxt_k  (rxk_i[0]),
    .hit_lo (hit_lo),
    .hit_hi (hit_hi)
  );

  rso_arm #(.ORD_MODE(ORD_MODE)) u_arm (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .en_i      (ord_en_i),
    .resync_i  (resync_i),
    .hit_lo    (hit_lo),
    .hit_hi    (hit_hi),
    .pad_now   (pad_now),
    .clr_shift (clr_shift),
    .flag_o    (ord_flag_o)
  );
endmodule

// File: rtl/rso_checker.sv
module rso_checker #(
  parameter int             SYM_W    = 8,
  parameter logic [SYM_W:0] ORD_SYM0 = 9'h1BC,
  parameter logic [SYM_W:0] PAD_SYM  = 9'h1F7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [2*SYM_W-1:0] rxd_i,
  input logic [1:0]         rxk_i,
  input logic [2*SYM_W-1:0] rxd_o,
  input logic [1:0]         rxk_o,
  input logic               ord_flag_o,
  input logic               pad_now,
  input logic               clr_shift,
  input logic               shifted
);
  logic [2:0] cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cyc_q <= '0;
    else if (cyc_q != 3'd7)  cyc_q <= cyc_q + 3'd1;
  end

  // R2
  passthru_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 3'd4 && !$past(shifted) && !$past(pad_now))
      |-> (rxd_o == $past(rxd_i, 2) && rxk_o == $past(rxk_i, 2)));

  // R4
  shift_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 3'd4 && $past(shifted) && !$past(pad_now))
      |-> (rxd_o[SYM_W-1:0] == $past(rxd_i[2*SYM_W-1:SYM_W], 3) &&
           rxd_o[2*SYM_W-1:SYM_W] == $past(rxd_i[SYM_W-1:0], 2)));

  // R3
  pad_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 3'd2 && $past(pad_now))
      |-> (ord_flag_o && rxd_o[SYM_W-1:0] == PAD_SYM[SYM_W-1:0]));

  // R5
  flag_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ord_flag_o |-> (rxd_o[SYM_W-1:0] == PAD_SYM[SYM_W-1:0] ||
                    rxd_o[SYM_W-1:0] == ORD_SYM0[SYM_W-1:0]));

  // R8
  single_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pad_now |-> !shifted);

  // R4
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shifted && !clr_shift) |=> shifted);
endmodule

bind rx_symbol_orderer rso_checker #(
  .SYM_W(SYM_W), .ORD_SYM0(ORD_SYM0), .PAD_SYM(PAD_SYM)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_s_n),
  .rxd_i      (rxd_i),
  .rxk_i      (rxk_i),
  .rxd_o      (rxd_o),
  .rxk_o      (rxk_o),
  .ord_flag_o (ord_flag_o),
  .pad_now    (pad_now),
  .clr_shift  (clr_shift),
  .shifted    (shifted)
);

// File: tb/rx_symbol_orderer_bench.sv
module rx_symbol_orderer_bench;
  logic        clk;
  logic        rst_n;
  logic [15:0] din  [3];
  logic [1:0]  kin  [3];
  logic        en   [3];
  logic        rs   [3];
  logic [15:0] dout [3];
  logic [1:0]  kout [3];
  logic        flg  [3];
  logic [15:0] obs_d [3];
  logic [1:0]  obs_k [3];
  logic        obs_f [3];
  int n_chk;
  int n_bad;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // auto, single symbol
  rx_symbol_orderer u_rx_symbol_orderer (
    .clk(clk), .rst_n(rst_n), .rxd_i(din[0]), .rxk_i(kin[0]), .ord_en_i(en[0]),
    .resync_i(rs[0]), .rxd_o(dout[0]), .rxk_o(kout[0]), .ord_flag_o(flg[0]));

  // manual, single symbol
  rx_symbol_orderer #(.ORD_MODE(rso_pkg::ORD_MANUAL)) u_rx_symbol_orderer_man (
    .clk(clk), .rst_n(rst_n), .rxd_i(din[1]), .rxk_i(kin[1]), .ord_en_i(en[1]),
    .resync_i(rs[1]), .rxd_o(dout[1]), .rxk_o(kout[1]), .ord_flag_o(flg[1]));

  // auto, two-symbol pattern
  rx_symbol_orderer #(.PAT_LEN(2)) u_rx_symbol_orderer_two (
    .clk(clk), .rst_n(rst_n), .rxd_i(din[2]), .rxk_i(kin[2]), .ord_en_i(en[2]),
    .resync_i(rs[2]), .rxd_o(dout[2]), .rxk_o(kout[2]), .ord_flag_o(flg[2]));

  // {data in, k in, expected data, expected k, expected flag}; each row's
  // expectation is the output produced by the row two steps earlier
  localparam logic [36:0] VEC [10] = '{
    {16'h1211, 2'b00, 16'h0000, 2'b00, 1'b0},
    {16'h1413, 2'b00, 16'h0000, 2'b00, 1'b0},
    {16'hBC15, 2'b10, 16'h1211, 2'b00, 1'b0},
    {16'h1716, 2'b00, 16'h1413, 2'b00, 1'b0},
    {16'hBC18, 2'b10, 16'h15F7, 2'b01, 1'b1},
    {16'h1ABC, 2'b01, 16'h16BC, 2'b01, 1'b0},
    {16'h1C1B, 2'b00, 16'h1817, 2'b00, 1'b0},
    {16'h0000, 2'b00, 16'hBCBC, 2'b11, 1'b0},
    {16'h0000, 2'b00, 16'h1B1A, 2'b00, 1'b0},
    {16'h0000, 2'b00, 16'h001C, 2'b00, 1'b0}
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  task automatic tick(input int u, input logic [15:0] d, input logic [1:0] k,
                      input logic e, input logic r);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      obs_d[i] = dout[i];
      obs_k[i] = kout[i];
      obs_f[i] = flg[i];
      din[i] = '0; kin[i] = '0; rs[i] = 1'b0;
      if (i != 1) en[i] = 1'b0;
    end
    din[u] = d; kin[u] = k; en[u] = e; rs[u] = r;
  endtask

  task automatic chk(input int u, input string req, input logic [15:0] ed,
                     input logic [1:0] ek, input logic ef);
    n_chk++;
    if (obs_d[u] !== ed || obs_k[u] !== ek || obs_f[u] !== ef) begin
      n_bad++;
      $display("FAIL %s unit%0d: got d=%h k=%b f=%b, expected d=%h k=%b f=%b",
               req, u, obs_d[u], obs_k[u], obs_f[u], ed, ek, ef);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog: run still going after 20000 cycles, expected to end");
    summary();
    $finish;
  end

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      din[i] = '0; kin[i] = '0; en[i] = 1'b0; rs[i] = 1'b0;
    end
    repeat (4) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      obs_d[i] = dout[i]; obs_k[i] = kout[i]; obs_f[i] = flg[i];
      chk(i, "R1", 16'h0000, 2'b00, 1'b0);
    end
    rst_n = 1'b1;
    repeat (4) tick(0, 16'h0, 2'b00, 1'b0, 1'b0);

    // table: R2 pass-through, R3 pad, R4 shift, R7 K travel, R8 later match ignored
    for (int j = 0; j < 10; j++) begin
      tick(0, VEC[j][36:21], VEC[j][20:19], 1'b0, 1'b0);
      chk(0, (j == 4) ? "R3" : (j >= 5) ? "R4/R8" : "R2", VEC[j][18:3], VEC[j][2:1], VEC[j][0]);
    end

    // R8 resync re-arms and restores pass-through; R7 K mismatch is no match
    tick(0, 16'h0000, 2'b00, 1'b0, 1'b1);
    tick(0, 16'hBC21, 2'b00, 1'b0, 1'b0);
    tick(0, 16'h23BC, 2'b01, 1'b0, 1'b0);
    tick(0, 16'h0000, 2'b00, 1'b0, 1'b0);
    chk(0, "R7", 16'hBC21, 2'b00, 1'b0);
    tick(0, 16'h0000, 2'b00, 1'b0, 1'b0);
    chk(0, "R5", 16'h23BC, 2'b01, 1'b1);
    tick(0, 16'h0000, 2'b00, 1'b0, 1'b0);
    chk(0, "R5", 16'h0000, 2'b00, 1'b0);

    // R10 both lanes hold the pattern
    tick(0, 16'h0000, 2'b00, 1'b0, 1'b1);
    tick(0, 16'hBCBC, 2'b11, 1'b0, 1'b0);
    tick(0, 16'h2524, 2'b00, 1'b0, 1'b0);
    tick(0, 16'h0000, 2'b00, 1'b0, 1'b0);
    chk(0, "R10", 16'hBCBC, 2'b11, 1'b1);
    tick(0, 16'h0000, 2'b00, 1'b0, 1'b0);
    chk(0, "R10", 16'h2524, 2'b00, 1'b0);

    // R9 manual mode
    tick(1, 16'hBC31, 2'b10, 1'b0, 1'b0);
    tick(1, 16'h0000, 2'b00, 1'b0, 1'b0);
    tick(1, 16'hBC35, 2'b10, 1'b1, 1'b0);
    chk(1, "R9", 16'hBC31, 2'b10, 1'b0);
    tick(1, 16'h3736, 2'b00, 1'b1, 1'b0);
    tick(1, 16'hBC38, 2'b10, 1'b1, 1'b1);
    chk(1, "R9", 16'h35F7, 2'b01, 1'b1);
    tick(1, 16'h3A39, 2'b00, 1'b1, 1'b0);
    chk(1, "R4", 16'h36BC, 2'b01, 1'b0);
    tick(1, 16'h0000, 2'b00, 1'b1, 1'b0);
    chk(1, "R9", 16'h3837, 2'b00, 1'b0);
    tick(1, 16'h0000, 2'b00, 1'b1, 1'b0);
    chk(1, "R9", 16'h39BC, 2'b01, 1'b0);
    tick(1, 16'h0000, 2'b00, 1'b0, 1'b0);
    tick(1, 16'h44BC, 2'b01, 1'b1, 1'b0);
    tick(1, 16'h0000, 2'b00, 1'b1, 1'b0);
    tick(1, 16'h0000, 2'b00, 1'b1, 1'b0);
    chk(1, "R9", 16'h44BC, 2'b01, 1'b1);
    tick(1, 16'h0000, 2'b00, 1'b0, 1'b0);

    // R6 two-symbol pattern
    tick(2, 16'hBC41, 2'b10, 1'b0, 1'b0);
    tick(2, 16'h433C, 2'b01, 1'b0, 1'b0);
    tick(2, 16'h4544, 2'b00, 1'b0, 1'b0);
    chk(2, "R6", 16'h41F7, 2'b01, 1'b1);
    tick(2, 16'h0000, 2'b00, 1'b0, 1'b0);
    chk(2, "R6", 16'h3CBC, 2'b11, 1'b0);
    tick(2, 16'h0000, 2'b00, 1'b0, 1'b0);
    chk(2, "R6", 16'h4443, 2'b00, 1'b0);
    tick(2, 16'h0000, 2'b00, 1'b0, 1'b1);
    tick(2, 16'hBC51, 2'b10, 1'b0, 1'b0);
    tick(2, 16'h5352, 2'b00, 1'b0, 1'b0);
    tick(2, 16'h3CBC, 2'b11, 1'b0, 1'b0);
    chk(2, "R6", 16'hBC51, 2'b10, 1'b0);
    tick(2, 16'h0000, 2'b00, 1'b0, 1'b0);
    chk(2, "R6", 16'h5352, 2'b00, 1'b0);
    tick(2, 16'h0000, 2'b00, 1'b0, 1'b0);
    chk(2, "R6", 16'h3CBC, 2'b11, 1'b1);

    summary();
    $finish;
  end
endmodule